// File: doc/BRIEF.md
# System Reset and NMI Event Vector Generator

This block gathers one-cycle event pulses from the reset logic, the supply and memory monitors, the debug mailbox and the external pins. It keeps them in three separate banks of sticky flags: reset cause, system-level non-maskable events and user-level non-maskable events. Each bank is visible as one read-only word on a simple peripheral bus. A read of that word returns an even code that names the most urgent pending event in the bank. The same read retires that one event, so software that reads a bank again and again receives its pending events in priority order and then 00h.

The reset-cause bank is cleared only by the power-on reset, which is `rst_n`. It therefore keeps a record of every reset cause that was pulsed since power-up, even when the rest of the chip has gone through warm resets in between. The two NMI banks each drive a request line that stays high while the bank holds any pending event.

Top module: `sysvec_gen`

## Requirements
- R1: After power-on reset (`rst_n` low), all three vector words read 00h, and both `snmi_req` and `unmi_req` are low.
- R2: Reset-cause input bit i (0..10) maps to code 2*(i+1). The bits are, in order: brownout, supply-monitor brownout, reset pin, software brownout reset, security violation, software power-on reset, watchdog timeout, watchdog key error, clock key error, power-manager key error and peripheral-area fetch. This gives codes 02h to 16h.
- R3: In every bank, the pending flag with the lowest code is reported first. A read clears only the flag it reported, so repeated reads walk down the pending list and then return 00h.
- R4: System NMI bit i (0..3) maps to code 2*(i+1). The bits are supply monitor 02h, vacant memory access 04h, mailbox input 06h and mailbox output 08h.
- R5: User NMI bit i (0..2) maps to code 2*(i+1). The bits are NMI pin 02h, oscillator fault 04h and bus error 06h.
- R6: `snmi_req` and `unmi_req` are high exactly while their own bank holds at least one pending flag. An event pulse raises its request at the next clock edge.
- R7: If an event pulse arrives in the same cycle as a read that retires the same flag, the flag stays pending.
- R8: The reset word is at byte offset 1Eh, the system NMI word at 1Ch and the user NMI word at 1Ah. Reads at any other offset return 0000h. Writes at any offset leave every flag unchanged.
- R9: `bus_rdata` is 0000h whenever no read is presented. Bits 15:6 and bit 0 of every returned code are zero.
- R10: Reading the NMI words never changes the reset-cause flags. A read that returns 00h clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; the only clear for the reset-cause flags |
| bus_sel | input | 1 | Bus access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset inside the system block |
| bus_wdata | input | 16 | Write data (ignored) |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the access |
| rst_evt | input | 11 | Reset-cause event pulses, bit order as in R2 |
| snmi_evt | input | 4 | System NMI event pulses, bit order as in R4 |
| unmi_evt | input | 3 | User NMI event pulses, bit order as in R5 |
| snmi_req | output | 1 | System NMI request |
| unmi_req | output | 1 | User NMI request |

## Verification
Read data is combinational, so the code for a read is due in the same cycle as the access, before the clock edge. The flag that the read retires, and any flag that an event pulse sets, change at that edge. A request line therefore reflects an event from the cycle after the pulse. The bench drives inputs on the falling edge and compares `bus_rdata` and both request lines shortly after that, against a flag model kept in the bench. The model is updated only after the rising edge, which matches that one-edge latency.

// File: rtl/sysvec_pkg.sv
package sysvec_pkg;
    localparam int RST_SRC   = 11;
    localparam int SNMI_SRC  = 4;
    localparam int UNMI_SRC  = 3;
    localparam int CODE_W    = 6;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;

    localparam logic [ADDR_W-1:0] OFS_RST  = 5'h1E;
    localparam logic [ADDR_W-1:0] OFS_SNMI = 5'h1C;
    localparam logic [ADDR_W-1:0] OFS_UNMI = 5'h1A;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RST  = 2'd1,
        SEL_SNMI = 2'd2,
        SEL_UNMI = 2'd3
    } bank_sel_e;

    // Event index i reports as code 2*(i+1); 0 means nothing pending.
    function automatic logic [CODE_W-1:0] code_of(input int idx);
        return CODE_W'((idx + 1) * 2);
    endfunction
endpackage

// File: rtl/sysvec_bank.sv
module sysvec_bank
    import sysvec_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt,
    input  logic              take,
    output logic [CODE_W-1:0] code,
    output logic              pend
);
    typedef struct packed {
        logic [NSRC-1:0] flags;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NSRC-1:0]   win_oh;
    logic [CODE_W-1:0] code_c;

    // Winner search: walk from the top so the lowest index is left standing.
    always_comb begin
        win_oh = '0;
        code_c = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (st_q.flags[i]) begin
                win_oh    = '0;
                win_oh[i] = 1'b1;
                code_c    = code_of(i);
            end
        end
        st_d = st_q;
        // A new event overrides the retirement of the same flag.
        st_d.flags = (st_q.flags & ~(take ? win_oh : '0)) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code = code_c;
    assign pend = |st_q.flags;
endmodule

// File: rtl/sysvec_gen.sv
module sysvec_gen
    import sysvec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [RST_SRC-1:0]  rst_evt,
    input  logic [SNMI_SRC-1:0] snmi_evt,
    input  logic [UNMI_SRC-1:0] unmi_evt,
    output logic              snmi_req,
    output logic              unmi_req
);
    bank_sel_e         sel_c;
    logic [CODE_W-1:0] rst_code, snmi_code, unmi_code, code_mux;
    logic              rst_pend;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    always_comb begin
        sel_c = SEL_NONE;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_RST:  sel_c = SEL_RST;
                OFS_SNMI: sel_c = SEL_SNMI;
                OFS_UNMI: sel_c = SEL_UNMI;
                default:  sel_c = SEL_NONE;
            endcase
        end
        case (sel_c)
            SEL_RST:  code_mux = rst_code;
            SEL_SNMI: code_mux = snmi_code;
            SEL_UNMI: code_mux = unmi_code;
            default:  code_mux = '0;
        endcase
    end

    assign bus_rdata = {{(DATA_W-CODE_W){1'b0}}, code_mux};

    sysvec_bank #(.NSRC(RST_SRC)) u_rst (
        .clk(clk), .rst_n(rst_n), .evt(rst_evt),
        .take(sel_c == SEL_RST), .code(rst_code), .pend(rst_pend)
    );

    sysvec_bank #(.NSRC(SNMI_SRC)) u_snmi (
        .clk(clk), .rst_n(rst_n), .evt(snmi_evt),
        .take(sel_c == SEL_SNMI), .code(snmi_code), .pend(snmi_req)
    );

    sysvec_bank #(.NSRC(UNMI_SRC)) u_unmi (
        .clk(clk), .rst_n(rst_n), .evt(unmi_evt),
        .take(sel_c == SEL_UNMI), .code(unmi_code), .pend(unmi_req)
    );
endmodule

// File: rtl/sysvec_chk.sv
module sysvec_chk
    import sysvec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SNMI_SRC-1:0] snmi_evt,
    input logic [UNMI_SRC-1:0] unmi_evt,
    input logic              snmi_req,
    input logic              unmi_req
);
    a_r6_snmi_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|snmi_evt) |=> snmi_req);
    a_r6_unmi_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|unmi_evt) |=> unmi_req);
    a_r6_snmi_drop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(snmi_req) |-> $past(bus_sel && !bus_wr && bus_addr == OFS_SNMI));
    a_r6_unmi_drop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unmi_req) |-> $past(bus_sel && !bus_wr && bus_addr == OFS_UNMI));
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |-> bus_rdata == '0);
    a_r9_even_code: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[0] == 1'b0 && bus_rdata[DATA_W-1:CODE_W] == '0);
    a_r2_rst_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_RST) |-> bus_rdata <= 16'h0016);
    a_r4_snmi_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_SNMI) |-> bus_rdata <= 16'h0008);
    a_r5_unmi_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_UNMI) |-> bus_rdata <= 16'h0006);
    a_r6_snmi_code_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_SNMI && bus_rdata != '0) |-> snmi_req);
endmodule

bind sysvec_gen sysvec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .snmi_evt(snmi_evt),
    .unmi_evt(unmi_evt), .snmi_req(snmi_req), .unmi_req(unmi_req)
);

// File: tb/tb_sysvec_gen.sv
module tb_sysvec_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [10:0] rst_evt = '0;
    logic [3:0]  snmi_evt = '0;
    logic [2:0]  unmi_evt = '0;
    logic        snmi_req, unmi_req;

    int n_chk = 0, n_fail = 0;
    logic [10:0] m_rst = '0;
    logic [3:0]  m_sn = '0;
    logic [2:0]  m_un = '0;

    always #5 clk = ~clk;

    sysvec_gen dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_evt(rst_evt), .snmi_evt(snmi_evt), .unmi_evt(unmi_evt),
        .snmi_req(snmi_req), .unmi_req(unmi_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] first_code(input logic [15:0] f, input int n);
        for (int i = 0; i < n; i++) if (f[i]) return 16'((i + 1) * 2);
        return 16'h0;
    endfunction

    // One bus cycle: drive at the falling edge, check before the rising edge,
    // then advance the model after the rising edge.
    task automatic cyc(input bit sel, input bit wr, input logic [4:0] a,
                       input logic [10:0] re, input logic [3:0] se, input logic [2:0] ue,
                       input string tag);
        logic [15:0] exp;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = 16'($urandom);
        rst_evt = re; snmi_evt = se; unmi_evt = ue;
        #1;
        exp = 16'h0;
        if (sel && !wr) begin
            if (a == 5'h1E)      exp = first_code(16'(m_rst), 11);
            else if (a == 5'h1C) exp = first_code(16'(m_sn), 4);
            else if (a == 5'h1A) exp = first_code(16'(m_un), 3);
        end
        chk(bus_rdata == exp, tag, bus_rdata, exp);
        chk(snmi_req == (|m_sn), "R6 snmi_req", 16'(snmi_req), 16'(|m_sn));
        chk(unmi_req == (|m_un), "R6 unmi_req", 16'(unmi_req), 16'(|m_un));
        @(posedge clk);
        if (sel && !wr && exp != 0) begin
            if (a == 5'h1E)      m_rst[exp/2-1] = 1'b0;
            else if (a == 5'h1C) m_sn[exp/2-1]  = 1'b0;
            else if (a == 5'h1A) m_un[exp/2-1]  = 1'b0;
        end
        m_rst |= re; m_sn |= se; m_un |= ue;
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        cyc(1'b1, 1'b0, a, '0, '0, '0, tag);
    endtask

    task automatic ev(input logic [10:0] re, input logic [3:0] se, input logic [2:0] ue);
        cyc(1'b0, 1'b0, 5'h0, re, se, ue, "R9 idle");
    endtask

    initial begin
        #1_500_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        rd(5'h1E, "R1 rst word"); rd(5'h1C, "R1 snmi word"); rd(5'h1A, "R1 unmi word");
        // R2/R4/R5: each source code on its own
        for (int i = 0; i < 11; i++) begin ev(11'(1 << i), '0, '0); rd(5'h1E, "R2 code map"); end
        for (int i = 0; i < 4; i++)  begin ev('0, 4'(1 << i), '0); rd(5'h1C, "R4 code map"); end
        for (int i = 0; i < 3; i++)  begin ev('0, '0, 3'(1 << i)); rd(5'h1A, "R5 code map"); end
        // R3: walk down pending list
        ev(11'b100_0000_1001, 4'b1010, 3'b110);
        for (int i = 0; i < 4; i++) rd(5'h1E, "R3 rst walk");
        for (int i = 0; i < 3; i++) rd(5'h1C, "R3 snmi walk");
        // R10: NMI reads leave reset flags alone
        ev(11'b000_0010_0000, '0, '0);
        rd(5'h1A, "R10 unmi read"); rd(5'h1A, "R10 unmi read"); rd(5'h1A, "R10 empty read");
        rd(5'h1C, "R10 snmi read");
        rd(5'h1E, "R10 rst kept"); rd(5'h1E, "R10 rst empty");
        // R7: event collides with the read that retires it
        ev(11'b1, 4'b1, 3'b1);
        cyc(1'b1, 1'b0, 5'h1E, 11'b1, '0, '0, "R7 rst collide");
        cyc(1'b1, 1'b0, 5'h1C, '0, 4'b1, '0, "R7 snmi collide");
        cyc(1'b1, 1'b0, 5'h1A, '0, '0, 3'b1, "R7 unmi collide");
        rd(5'h1E, "R7 rst still"); rd(5'h1C, "R7 snmi still"); rd(5'h1A, "R7 unmi still");
        // R8: writes and other offsets
        ev(11'b10, 4'b10, 3'b10);
        cyc(1'b1, 1'b1, 5'h1E, '0, '0, '0, "R8 write rst");
        cyc(1'b1, 1'b1, 5'h1C, '0, '0, '0, "R8 write snmi");
        cyc(1'b1, 1'b1, 5'h1A, '0, '0, '0, "R8 write unmi");
        rd(5'h18, "R8 other offset"); rd(5'h1F, "R8 other offset");
        rd(5'h1E, "R8 rst after write"); rd(5'h1C, "R8 snmi after write");
        rd(5'h1A, "R8 unmi after write");
        // R3: random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [4:0] a;
            int r;
            r = int'($urandom_range(0, 7));
            a = (r < 2) ? 5'h1E : (r < 4) ? 5'h1C : (r < 6) ? 5'h1A : 5'($urandom);
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0, a,
                ($urandom_range(0, 5) == 0) ? 11'(1 << $urandom_range(0, 10)) : '0,
                ($urandom_range(0, 4) == 0) ? 4'($urandom) : '0,
                ($urandom_range(0, 4) == 0) ? 3'($urandom) : '0,
                "R3 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule